// File: doc/BRIEF.md
# Four-Part Music Event Sequencer

This block plays back a stream of 16-bit score events for a four-voice tone generator. It reads events from a show-ahead score FIFO and decodes each one as a note or a rest. It then waits a coded number of musical ticks before it takes the next event. A note raises a one-cycle key-on strobe for its part and presents the octave block, pitch code and vibrato flag. The note also arms a per-part length timer, and that timer raises a key-off strobe when it runs out. Rests produce no sound. A rest can carry a timbre-change command for a part, and that command takes effect when the part plays its next note.

Timing comes from a tempo-derived tick. The tick is one pulse in every (tempo + 1) pulses of an external base strobe, and a whole note lasts 48 ticks. Gaps and lengths are taken from fixed code tables. The timbre allocation register lives outside the block. The sequencer reads its current value and returns a rewritten copy, together with a write strobe.

Top module: `score_sequencer`

## Requirements
- R1: After reset, all key strobes, sounding flags, the allocation write strobe and the FIFO pop are low.
- R2: A tick occurs on every (tempo+1)-th base-strobe pulse counted while run is high. All gaps and lengths are counted in these ticks.
- R3: In a note event, bits 9:8 select the part, bits 15:14 are the octave block, bits 13:10 are the pitch and bit 7 is vibrato. The key-on strobe of that part (`key_on[part]`) and the fields appear in the cycle after the event is popped, and no other part is affected.
- R4: Bits 6:3 form the interval code, which selects the gap to the next event: 0→0, 1→2, 2→3, 3→4, 4→6, 5→8, 6→9, 7→12, 8→18, 9→24, A→48, B→0, C→16, D→24, E→36, F→48 ticks. For a popped event, the next pop comes that many ticks later.
- R5: An interval of 0 ticks makes the next event pop on the very next clock when the FIFO holds data.
- R6: For interval codes 0 to A, the length code in bits 2:0 gives 1, 2, 3, 5, 7, 8, 11 or 17 ticks, and key-off is strobed at the end of that many ticks.
- R7: For interval codes B to F, the length code gives 15, 23, 29, 32, 35, 41 or 47 ticks. Code 7 in this range is a tie, and a tie never strobes key-off by itself.
- R8: An event whose bits 15:10 are 001100 is a rest. A rest gives no key-on, but its interval code is still applied.
- R9: A rest with bit 7 set stores bits 2:0 as a new timbre for its part. On that part's next note, `alloc_wr` pulses together with the key-on. `alloc_wdata` then equals `alloc_cur` with bits 4p+2:4p replaced by the stored value.
- R10: While an event is due and the FIFO is empty, ticks are held back, so no length timer advances and no key-off occurs. Play resumes when data arrives.
- R11: While run is low, nothing is popped. Dropping run strobes key-off once for every sounding part and clears all sounding flags.
- R12: A pop is issued only while the FIFO reports data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_strobe | input | 1 | Base timing pulse, one clock wide |
| tempo | input | 8 | Tempo divider value |
| run | input | 1 | Play enable |
| fifo_data | input | 16 | Head event of the score FIFO |
| fifo_empty | input | 1 | Score FIFO holds no event |
| fifo_pop | output | 1 | Consume the head event |
| alloc_cur | input | 16 | Current timbre allocation register |
| key_on | output | 4 | Key-on strobe per part |
| key_off | output | 4 | Key-off strobe per part |
| sounding | output | 4 | Part currently keyed |
| part_block | output | 8 | Octave block per part, 2 bits each |
| part_pitch | output | 16 | Pitch code per part, 4 bits each |
| part_vib | output | 4 | Vibrato flag per part |
| alloc_wr | output | 1 | Allocation register write strobe |
| alloc_wdata | output | 16 | New allocation register value |

## Verification
The bench builds the block with its default parameters: four parts, an 8-bit tempo and 3-bit timbre fields on a 4-bit stride. With these values, every part, every field position of the allocation register and every table branch can be reached. The tempo register is set to 2 with a strobe on every clock, so a 48-tick gap ends within about 150 cycles and exact cycle distances for gaps and lengths stay easy to predict. A second run uses a tempo of 9 with a strobe on every other clock to confirm that the tick divider scales with both the tempo value and the strobe rate.

// File: rtl/seq_pkg.sv
package seq_pkg;

   localparam int            EV_W       = 16;
   localparam int            TICK_W     = 6;
   localparam logic [5:0]    REST_TAG   = 6'b001100;
   localparam logic [3:0]    LONG_FIRST = 4'hB;
   localparam logic [2:0]    TIE_CODE   = 3'd7;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_FETCH = 2'd1,
      SQ_WAIT  = 2'd2
   } sq_state_t;

   typedef struct packed {
      logic              is_rest;
      logic [1:0]        part;
      logic [1:0]        blk;
      logic [3:0]        pitch;
      logic              vib;
      logic [TICK_W-1:0] gap;
      logic [TICK_W-1:0] len;
      logic              tie;
      logic              tch_en;
      logic [2:0]        tch_sel;
   } ev_fields_t;

   // interval code to gap in ticks (48 ticks per whole note)
   function automatic logic [TICK_W-1:0] gap_ticks(input logic [3:0] code);
      logic [TICK_W-1:0] g;
      case (code)
         4'h0:    g = 6'd0;
         4'h1:    g = 6'd2;
         4'h2:    g = 6'd3;
         4'h3:    g = 6'd4;
         4'h4:    g = 6'd6;
         4'h5:    g = 6'd8;
         4'h6:    g = 6'd9;
         4'h7:    g = 6'd12;
         4'h8:    g = 6'd18;
         4'h9:    g = 6'd24;
         4'hA:    g = 6'd48;
         4'hB:    g = 6'd0;
         4'hC:    g = 6'd16;
         4'hD:    g = 6'd24;
         4'hE:    g = 6'd36;
         default: g = 6'd48;
      endcase
      return g;
   endfunction

   // length code to sounding ticks; zero marks a tie
   function automatic logic [TICK_W-1:0] len_ticks(input logic [3:0] icode,
                                                   input logic [2:0] lcode);
      logic [TICK_W-1:0] l;
      if (icode < LONG_FIRST) begin
         case (lcode)
            3'd0:    l = 6'd1;
            3'd1:    l = 6'd2;
            3'd2:    l = 6'd3;
            3'd3:    l = 6'd5;
            3'd4:    l = 6'd7;
            3'd5:    l = 6'd8;
            3'd6:    l = 6'd11;
            default: l = 6'd17;
         endcase
      end else begin
         case (lcode)
            3'd0:    l = 6'd15;
            3'd1:    l = 6'd23;
            3'd2:    l = 6'd29;
            3'd3:    l = 6'd32;
            3'd4:    l = 6'd35;
            3'd5:    l = 6'd41;
            3'd6:    l = 6'd47;
            default: l = 6'd0;
         endcase
      end
      return l;
   endfunction

endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen #(
   parameter int TEMPO_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               strobe,
   input  logic [TEMPO_W-1:0] tempo,
   output logic               tick
);

   logic [TEMPO_W-1:0] cnt;
   logic               at_end;

   assign at_end = (cnt >= tempo);
   assign tick   = en & strobe & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!en)
         cnt <= '0;
      else if (strobe)
         cnt <= at_end ? '0 : cnt + TEMPO_W'(1);
   end

   // a divider above one never yields ticks on consecutive clocks
   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && tempo != '0 && $stable(tempo)) |=> !tick);

endmodule

// File: rtl/seq_event_decode.sv
module seq_event_decode
   import seq_pkg::*;
(
   input  logic [EV_W-1:0] word,
   output ev_fields_t      ev
);

   logic [3:0] icode;
   logic [2:0] lcode;

   assign icode = word[6:3];
   assign lcode = word[2:0];

   always_comb begin
      ev.is_rest = (word[15:10] == REST_TAG);
      ev.part    = word[9:8];
      ev.blk     = word[15:14];
      ev.pitch   = word[13:10];
      ev.vib     = word[7];
      ev.gap     = gap_ticks(icode);
      ev.len     = len_ticks(icode, lcode);
      ev.tie     = (icode >= LONG_FIRST) && (lcode == TIE_CODE);
      ev.tch_en  = word[7];
      ev.tch_sel = lcode;
   end

endmodule

// File: rtl/seq_part_voice.sv
module seq_part_voice
   import seq_pkg::*;
#(
   parameter int BLK_W   = 2,
   parameter int PITCH_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stop,
   input  logic               load,
   input  logic               tick,
   input  logic [BLK_W-1:0]   in_blk,
   input  logic [PITCH_W-1:0] in_pitch,
   input  logic               in_vib,
   input  logic [TICK_W-1:0]  in_len,
   input  logic               in_tie,
   output logic               key_on,
   output logic               key_off,
   output logic               sounding,
   output logic [BLK_W-1:0]   blk,
   output logic [PITCH_W-1:0] pitch,
   output logic               vib
);

   logic [TICK_W-1:0] remain;
   logic              tie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_on   <= 1'b0;
         key_off  <= 1'b0;
         sounding <= 1'b0;
         tie_q    <= 1'b0;
         remain   <= '0;
         blk      <= '0;
         pitch    <= '0;
         vib      <= 1'b0;
      end else if (stop) begin
         key_on   <= 1'b0;
         key_off  <= sounding;
         sounding <= 1'b0;
         tie_q    <= 1'b0;
         remain   <= '0;
      end else if (load) begin
         key_on   <= 1'b1;
         key_off  <= 1'b0;
         sounding <= 1'b1;
         tie_q    <= in_tie;
         remain   <= in_len;
         blk      <= in_blk;
         pitch    <= in_pitch;
         vib      <= in_vib;
      end else begin
         key_on  <= 1'b0;
         key_off <= 1'b0;
         if (sounding && !tie_q && tick) begin
            if (remain <= TICK_W'(1)) begin
               key_off  <= 1'b1;
               sounding <= 1'b0;
               remain   <= '0;
            end else begin
               remain <= remain - TICK_W'(1);
            end
         end
      end
   end

   assert_keyon_sounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      key_on |-> sounding);

   assert_keyoff_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      key_off |-> !sounding);

   assert_tie_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sounding && tie_q && !stop && !load) |=> !key_off);

endmodule

// File: rtl/score_sequencer.sv
module score_sequencer
   import seq_pkg::*;
#(
   parameter  int NUM_PARTS    = 4,
   parameter  int TEMPO_W      = 8,
   parameter  int TIMBRE_W     = 3,
   parameter  int FIELD_STRIDE = 4,
   localparam int PART_W       = $clog2(NUM_PARTS),
   localparam int ALLOC_W      = NUM_PARTS * FIELD_STRIDE
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   base_strobe,
   input  logic [TEMPO_W-1:0]     tempo,
   input  logic                   run,
   input  logic [EV_W-1:0]        fifo_data,
   input  logic                   fifo_empty,
   output logic                   fifo_pop,
   input  logic [ALLOC_W-1:0]     alloc_cur,
   output logic [NUM_PARTS-1:0]   key_on,
   output logic [NUM_PARTS-1:0]   key_off,
   output logic [NUM_PARTS-1:0]   sounding,
   output logic [2*NUM_PARTS-1:0] part_block,
   output logic [4*NUM_PARTS-1:0] part_pitch,
   output logic [NUM_PARTS-1:0]   part_vib,
   output logic                   alloc_wr,
   output logic [ALLOC_W-1:0]     alloc_wdata
);

   // elaboration checks: the event word carries a 2-bit part and 3-bit timbre
   if (NUM_PARTS != 4) begin : g_bad_parts
      $error("score_sequencer: event format addresses exactly four parts");
   end
   if (TIMBRE_W != 3) begin : g_bad_timbre
      $error("score_sequencer: rest events carry a 3-bit timbre number");
   end
   if (FIELD_STRIDE < TIMBRE_W) begin : g_bad_stride
      $error("score_sequencer: allocation field stride narrower than timbre");
   end
   if (TEMPO_W < 1) begin : g_bad_tempo
      $error("score_sequencer: tempo width must be positive");
   end

   sq_state_t         state;
   ev_fields_t        d;
   logic              tick_raw;
   logic              tick_use;
   logic              stall;
   logic              pop;
   logic [TICK_W-1:0] gap_cnt;

   seq_tick_gen #(.TEMPO_W(TEMPO_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (run),
      .strobe (base_strobe),
      .tempo  (tempo),
      .tick   (tick_raw)
   );

   seq_event_decode u_dec (
      .word (fifo_data),
      .ev   (d)
   );

   assign stall    = (state == SQ_FETCH) && fifo_empty;
   assign pop      = run && (state == SQ_FETCH) && !fifo_empty;
   assign fifo_pop = pop;
   assign tick_use = tick_raw && !stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         gap_cnt <= '0;
      end else if (!run) begin
         state   <= SQ_IDLE;
         gap_cnt <= '0;
      end else begin
         case (state)
            SQ_IDLE:  state <= SQ_FETCH;
            SQ_FETCH: if (pop) begin
                         gap_cnt <= d.gap;
                         state   <= (d.gap == '0) ? SQ_FETCH : SQ_WAIT;
                      end
            SQ_WAIT:  if (tick_use) begin
                         if (gap_cnt == TICK_W'(1)) state <= SQ_FETCH;
                         gap_cnt <= gap_cnt - TICK_W'(1);
                      end
            default:  state <= SQ_IDLE;
         endcase
      end
   end

   // per-part voices
   for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
      logic load_p;
      assign load_p = pop && !d.is_rest && (d.part == PART_W'(p));

      seq_part_voice #(.BLK_W(2), .PITCH_W(4)) u_voice (
         .clk      (clk),
         .rst_n    (rst_n),
         .stop     (!run),
         .load     (load_p),
         .tick     (tick_use),
         .in_blk   (d.blk),
         .in_pitch (d.pitch),
         .in_vib   (d.vib),
         .in_len   (d.len),
         .in_tie   (d.tie),
         .key_on   (key_on[p]),
         .key_off  (key_off[p]),
         .sounding (sounding[p]),
         .blk      (part_block[2*p +: 2]),
         .pitch    (part_pitch[4*p +: 4]),
         .vib      (part_vib[p])
      );
   end

   // deferred timbre reassignment
   logic [NUM_PARTS-1:0] pend;
   logic [TIMBRE_W-1:0]  pend_sel [NUM_PARTS];
   logic [ALLOC_W-1:0]   merged;

   always_comb begin
      merged = alloc_cur;
      for (int p = 0; p < NUM_PARTS; p++) begin
         if (d.part == PART_W'(p))
            merged[p*FIELD_STRIDE +: TIMBRE_W] = pend_sel[p];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend        <= '0;
         alloc_wr    <= 1'b0;
         alloc_wdata <= '0;
         for (int p = 0; p < NUM_PARTS; p++) pend_sel[p] <= '0;
      end else begin
         alloc_wr <= 1'b0;
         if (pop && d.is_rest && d.tch_en) begin
            pend[d.part]     <= 1'b1;
            pend_sel[d.part] <= d.tch_sel;
         end else if (pop && !d.is_rest && pend[d.part]) begin
            pend[d.part] <= 1'b0;
            alloc_wr     <= 1'b1;
            alloc_wdata  <= merged;
         end
      end
   end

   assert_keyon_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(key_on));

   assert_gap_spaces_pops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && d.gap != '0) |=> !fifo_pop);

   assert_zero_gap_refetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && d.gap == '0) |=> (!run || fifo_empty || fifo_pop));

   assert_alloc_with_note_R9: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_wr |-> (key_on != '0));

   assert_starve_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && stall) |=> (key_off == '0));

   assert_stop_silences_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (key_on == '0 && !fifo_pop));

endmodule

// File: tb/sim_score_sequencer.sv
`timescale 1ns/1ps
module sim_score_sequencer;

   logic        clk;
   logic        rst_n;
   logic        base_strobe;
   logic [7:0]  tempo;
   logic        run;
   logic [15:0] fifo_data;
   logic        fifo_empty;
   logic        fifo_pop;
   logic [15:0] alloc_cur;
   logic [3:0]  key_on, key_off, sounding, part_vib;
   logic [7:0]  part_block;
   logic [15:0] part_pitch;
   logic        alloc_wr;
   logic [15:0] alloc_wdata;

   int n_chk  = 0;
   int n_fail = 0;

   score_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .base_strobe(base_strobe), .tempo(tempo),
      .run(run), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
      .fifo_pop(fifo_pop), .alloc_cur(alloc_cur), .key_on(key_on),
      .key_off(key_off), .sounding(sounding), .part_block(part_block),
      .part_pitch(part_pitch), .part_vib(part_vib), .alloc_wr(alloc_wr),
      .alloc_wdata(alloc_wdata)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   // base strobe: one pulse every sdiv clocks
   int sdiv = 1;
   int sph  = 0;
   initial begin
      base_strobe = 1'b0;
      forever begin
         @(posedge clk); #1;
         sph = (sph + 1 >= sdiv) ? 0 : sph + 1;
         base_strobe = (sph == 0);
      end
   end

   // show-ahead score FIFO model
   logic [15:0] fmem [64];
   int  wr_ptr = 0;
   int  rd_ptr = 0;
   logic fifo_clr = 1'b0;
   always @(posedge clk) begin
      if (fifo_clr) rd_ptr <= 0;
      else if (fifo_pop) rd_ptr <= rd_ptr + 1;
   end
   assign fifo_empty = (rd_ptr == wr_ptr);
   assign fifo_data  = fmem[rd_ptr % 64];

   // output monitor, sampled on the falling edge
   logic mon_clr = 1'b0;
   int cyc = 0;
   int pop_n, alloc_n, alloc_c, bad_pop;
   int pop_c [16];
   int on_n [4];
   int off_n [4];
   int on_c [4];
   int off_c [4];
   logic [1:0]  cap_blk [4];
   logic [3:0]  cap_pitch [4];
   logic        cap_vib [4];
   logic [15:0] cap_alloc;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (mon_clr) begin
         pop_n = 0; alloc_n = 0; alloc_c = 0; bad_pop = 0; cap_alloc = '0;
         for (int p = 0; p < 4; p++) begin
            on_n[p] = 0; off_n[p] = 0; on_c[p] = 0; off_c[p] = 0;
            cap_blk[p] = '0; cap_pitch[p] = '0; cap_vib[p] = 1'b0;
         end
      end else begin
         if (fifo_pop) begin
            if (fifo_empty) bad_pop = bad_pop + 1;
            if (pop_n < 16) pop_c[pop_n] = cyc;
            pop_n = pop_n + 1;
         end
         for (int p = 0; p < 4; p++) begin
            if (key_on[p]) begin
               on_n[p] = on_n[p] + 1; on_c[p] = cyc;
               cap_blk[p]   = part_block[2*p +: 2];
               cap_pitch[p] = part_pitch[4*p +: 4];
               cap_vib[p]   = part_vib[p];
            end
            if (key_off[p]) begin
               off_n[p] = off_n[p] + 1; off_c[p] = cyc;
            end
         end
         if (alloc_wr) begin
            alloc_n = alloc_n + 1; alloc_c = cyc; cap_alloc = alloc_wdata;
         end
      end
   end

   function automatic logic [15:0] mk_note(input logic [1:0] blk, input logic [3:0] pit,
                                           input logic [1:0] part, input logic vib,
                                           input logic [3:0] ic, input logic [2:0] lc);
      return {blk, pit, part, vib, ic, lc};
   endfunction

   function automatic logic [15:0] mk_rest(input logic [1:0] part, input logic en,
                                           input logic [3:0] ic, input logic [2:0] sel);
      return {6'b001100, part, en, ic, sel};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic push(input logic [15:0] w);
      fmem[wr_ptr % 64] = w;
      wr_ptr = wr_ptr + 1;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input logic [7:0] tmp, input int div);
      @(posedge clk); #1;
      rst_n = 1'b0; run = 1'b0; tempo = tmp; sdiv = div;
      wr_ptr = 0; fifo_clr = 1'b1; mon_clr = 1'b1;
      @(posedge clk); #1;
      fifo_clr = 1'b0; mon_clr = 1'b0;
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(1);
   endtask

   task automatic play(input int pops, input int tmo, input int extra);
      run = 1'b1;
      for (int i = 0; i < tmo && pop_n < pops; i++) @(posedge clk);
      #1;
      wait_cyc(extra);
   endtask

   task automatic t_reset;
      do_reset(8'd2, 1);
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      wait_cyc(20);
      @(negedge clk);
      chk("R1 key_on", key_on, 0);
      chk("R1 key_off", key_off, 0);
      chk("R1 sounding", sounding, 0);
      chk("R1 alloc_wr", alloc_wr, 0);
      chk("R1 fifo_pop", fifo_pop, 0);
      chk("R11 no pop while stopped", pop_n, 0);
   endtask

   task automatic t_note;
      do_reset(8'd2, 1);
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      push(mk_note(2'd2, 4'h5, 2'd2, 1'b1, 4'h5, 3'd3));
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      play(3, 400, 30);
      chk("R3 key_on count part2", on_n[2], 1);
      chk("R3 block", cap_blk[2], 2);
      chk("R3 pitch", cap_pitch[2], 5);
      chk("R3 vibrato", cap_vib[2], 1);
      chk("R3 other parts idle", on_n[0] + on_n[1] + on_n[3], 0);
      chk("R3 key_on one cycle after pop", on_c[2] - pop_c[1], 1);
      chk("R6 length 5 ticks", off_c[2] - on_c[2], 14);
      chk("R4 gap 8 ticks", pop_c[2] - pop_c[1], 24);
      run = 1'b0;
   endtask

   task automatic t_chain;
      do_reset(8'd2, 1);
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      push(mk_note(2'd1, 4'hF, 2'd1, 1'b0, 4'h0, 3'd0));
      push(mk_note(2'd3, 4'h2, 2'd3, 1'b0, 4'hB, 3'd2));
      push(mk_note(2'd1, 4'h9, 2'd0, 1'b0, 4'hF, 3'd7));
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      play(5, 800, 20);
      chk("R5 zero gap back to back", pop_c[2] - pop_c[1], 1);
      chk("R7 code B zero gap", pop_c[3] - pop_c[2], 1);
      chk("R6 length 1 tick", off_c[1] - on_c[1], 2);
      chk("R7 long length 29 ticks", off_c[3] - on_c[3], 85);
      chk("R7 tie keeps key", off_n[0], 0);
      chk("R7 tie still sounding", sounding[0], 1);
      run = 1'b0;
   endtask

   task automatic t_timbre;
      do_reset(8'd2, 1);
      alloc_cur = 16'h7654;
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      push(mk_rest(2'd1, 1'b1, 4'h0, 3'd2));
      push(mk_note(2'd2, 4'h3, 2'd3, 1'b0, 4'h0, 3'd0));
      push(mk_note(2'd2, 4'h3, 2'd1, 1'b0, 4'h1, 3'd0));
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      play(5, 400, 20);
      chk("R8 rest gives no key_on", on_n[0] + on_n[2], 0);
      chk("R8 rest interval 0 applied", pop_c[2] - pop_c[1], 1);
      chk("R9 single allocation write", alloc_n, 1);
      chk("R9 field 6:4 rewritten", cap_alloc, 16'h7624);
      chk("R9 write with next note of part", alloc_c, on_c[1]);
      chk("R9 other part note played", on_n[3], 1);
      run = 1'b0;
   endtask

   task automatic t_stall_stop;
      do_reset(8'd2, 1);
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      push(mk_note(2'd1, 4'h2, 2'd2, 1'b0, 4'hB, 3'd7));
      push(mk_note(2'd1, 4'h6, 2'd0, 1'b0, 4'h1, 3'd7));
      play(3, 400, 200);
      chk("R10 key held while starved", sounding[0], 1);
      chk("R10 no key_off while starved", off_n[0], 0);
      push(mk_rest(2'd0, 1'b0, 4'hA, 3'd0));
      wait_cyc(80);
      chk("R10 resumes on new data", pop_n, 4);
      chk("R10 length finishes after resume", off_n[0], 1);
      run = 1'b0;
      wait_cyc(5);
      chk("R11 stop keys off tied part", off_n[2], 1);
      chk("R11 stop clears sounding", sounding, 0);
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      wait_cyc(20);
      chk("R11 no pop after stop", pop_n, 4);
   endtask

   task automatic t_tempo;
      do_reset(8'd9, 2);
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      push(mk_note(2'd1, 4'h2, 2'd0, 1'b0, 4'h3, 3'd1));
      push(mk_rest(2'd0, 1'b0, 4'h1, 3'd0));
      play(3, 1000, 20);
      chk("R2 gap 4 ticks at 20 clocks per tick", pop_c[2] - pop_c[1], 80);
      chk("R2 length 2 ticks at 20 clocks per tick", off_c[0] - on_c[0], 39);
      chk("R12 no pop on empty", bad_pop, 0);
      run = 1'b0;
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      rst_n = 1'b0; run = 1'b0; tempo = 8'd2; alloc_cur = 16'h0000;
      t_reset();
      t_note();
      t_chain();
      t_timbre();
      t_stall_stop();
      t_tempo();
      report();
      $finish;
   end

   initial begin
      #750000;
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
   end

endmodule